// File: doc/BRIEF.md
# Command/Response Bus Controller Interrupt Sequencer

This block is the host-facing control section of a serial command/response bus controller. The CPU programs an interrupt enable register and issues start and reset commands through a small register window. The protocol engine reports each finished message and any fault through single-cycle event pulses. The block turns these pulses into sticky event flags, raises one interrupt line, and, in bus-controller mode, counts transferred messages against a requested total. That total is given as the one's complement of the message count.

A start command in bus-controller mode loads the count and raises `ctrl_active`. Every message-done pulse then advances the count. When the count reaches all ones, the run is over: `ctrl_active` falls and the run-complete flag is set. In monitor mode a start only enables reception. A reset command returns the block to its power-on state and pulses `cfg_clear`, which clears the neighbouring configuration register.

Top module: `bcx_irq_seq`

## Requirements
- R1: While `rst_n` is low and after it rises, the enable register, the flags and the count are zero, and `irq`, `ctrl_active` and `cfg_clear` are low.
- R2: Address 0 is the enable register. A write keeps only bits 0 (message done), 1 (fault) and 4 (run complete) of `host_wdata`. A read returns the stored bits, and every other bit reads as zero.
- R3: Address 1 is the write-only command register, and reading it returns zero. Bit 0 of a write is reset and bit 1 is start. Address 3 also reads zero.
- R4: A write with bit 0 set clears the enable register, the flags, the count and `ctrl_active` at that clock edge. `cfg_clear` is then high for exactly the following cycle. If reset and start are in the same write, only reset takes effect.
- R5: A `ev_msg_done` pulse sets flag bit 0 when `mode` is 0 (bus controller) or 1 (remote terminal). It does not set the flag when `mode` is 2 or 3 (monitor). The pulse sets the flag whether or not the message was valid.
- R6: A pulse on any of `ev_loop_fail`, `ev_msg_err`, `ev_timeout` or `ev_status_set` sets flag bit 1.
- R7: A start in bus-controller mode loads `cnt_init`, so the run is 16'hFFFF minus `cnt_init` messages. `ctrl_active` rises after that edge. Each `ev_msg_done` while active adds one to the count. The edge that brings the count to 16'hFFFF drops `ctrl_active` and sets flag bit 4.
- R8: A `cnt_init` that asks for more than MAX_MSGS messages is limited to MAX_MSGS messages. A `cnt_init` of 16'hFFFF sets flag bit 4 at the start edge and leaves `ctrl_active` low.
- R9: A start in monitor mode raises `ctrl_active`, and message-done pulses do not lower it. A start in remote-terminal mode has no effect.
- R10: Address 2 returns the flags at their bit positions. A read there clears them at the clock edge, but an event in the same cycle leaves its own flag set.
- R11: `irq` is high exactly when some flag is set together with its enable bit. With IRQ_REG = 0 it follows in the same cycle as the flags, and with IRQ_REG = 1 it follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (needed for read-clear of status) |
| host_addr | input | ADDR_W | Register select: 0 enable, 1 command, 2 status |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, combinational from address and state |
| mode | input | 2 | 0 bus controller, 1 remote terminal, 2/3 monitor |
| cnt_init | input | CNT_W | One's-complement message count used at start |
| ev_msg_done | input | 1 | Message transfer finished |
| ev_loop_fail | input | 1 | Transmitted/received word mismatch |
| ev_msg_err | input | 1 | Received message in error |
| ev_timeout | input | 1 | Expected response missing |
| ev_status_set | input | 1 | Status word with bits set or bad address |
| irq | output | 1 | Interrupt to CPU |
| ctrl_active | output | 1 | Controller running |
| cfg_clear | output | 1 | One-cycle clear for the configuration register |

## Verification
The bench builds the block with MAX_MSGS = 4 and IRQ_REG = 0, and leaves the 16-bit count width at its default. With the small limit, the clamp floor is 16'hFFFB, so both the over-limit clamp and a complete run finish within a handful of message pulses, while the load arithmetic still uses the full-width one's-complement value. The same-cycle interrupt variant lets the reference model compare `irq` against the flags and enables of the same edge.

// File: rtl/bcx_pkg.sv
package bcx_pkg;

   typedef enum logic [1:0] {
      MODE_BC   = 2'd0,
      MODE_RT   = 2'd1,
      MODE_MON  = 2'd2,
      MODE_MON2 = 2'd3
   } bcx_mode_e;

   // flag / enable bit positions (shared by status and enable registers)
   localparam int EOM_BIT   = 0;
   localparam int FMT_BIT   = 1;
   localparam int RUN_BIT   = 4;

   // command register bits
   localparam int CMD_RST_BIT   = 0;
   localparam int CMD_START_BIT = 1;

   // register addresses
   localparam int ADDR_MASK = 0;
   localparam int ADDR_CMD  = 1;
   localparam int ADDR_STAT = 2;

   localparam int NUM_FAULTS = 4;

endpackage

// File: rtl/bcx_host_regs.sv
module bcx_host_regs
   import bcx_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 2,
   parameter int MASK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [MASK_W-1:0] flags,
   output logic              soft_rst,
   output logic              start_cmd,
   output logic              stat_rd,
   output logic [MASK_W-1:0] mask_q,
   output logic              cfg_clear,
   output logic [DATA_W-1:0] host_rdata
);

   localparam logic [MASK_W-1:0] USED_BITS =
      MASK_W'((1 << EOM_BIT) | (1 << FMT_BIT) | (1 << RUN_BIT));

   logic sel_mask;
   logic sel_cmd;
   logic sel_stat;

   always_comb begin
      sel_mask  = (host_addr == ADDR_W'(ADDR_MASK));
      sel_cmd   = (host_addr == ADDR_W'(ADDR_CMD));
      sel_stat  = (host_addr == ADDR_W'(ADDR_STAT));
      soft_rst  = host_wr && sel_cmd && host_wdata[CMD_RST_BIT];
      start_cmd = host_wr && sel_cmd && host_wdata[CMD_START_BIT] && !soft_rst;
      stat_rd   = host_rd && sel_stat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         cfg_clear <= 1'b0;
      end else begin
         cfg_clear <= soft_rst;
         if (soft_rst)
            mask_q <= '0;
         else if (host_wr && sel_mask)
            mask_q <= host_wdata[MASK_W-1:0] & USED_BITS;
      end
   end

   always_comb begin
      host_rdata = '0;
      if (sel_mask)
         host_rdata = DATA_W'(mask_q);
      else if (sel_stat)
         host_rdata = DATA_W'(flags);
   end

endmodule

// File: rtl/bcx_msg_seq.sv
module bcx_msg_seq
   import bcx_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int MAX_MSGS = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             start_cmd,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] cnt_init,
   input  logic             msg_done,
   output logic             active_q,
   output logic             run_done,
   output logic [CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] FLOOR    = ALL_ONES - CNT_W'(MAX_MSGS);

   logic             is_bc;
   logic             is_mon;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] step;
   logic             empty_run;
   logic             last_msg;

   always_comb begin
      is_bc     = (mode == MODE_BC);
      is_mon    = mode[1];
      load_val  = (cnt_init < FLOOR) ? FLOOR : cnt_init;
      step      = cnt_q + 1'b1;
      empty_run = start_cmd && is_bc && (load_val == ALL_ONES);
      last_msg  = !start_cmd && active_q && is_bc && msg_done && (step == ALL_ONES);
      run_done  = !soft_rst && (empty_run || last_msg);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (soft_rst) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (start_cmd) begin
         if (is_bc) begin
            cnt_q    <= load_val;
            active_q <= (load_val != ALL_ONES);
         end else if (is_mon) begin
            active_q <= 1'b1;
         end
      end else if (active_q && is_bc && msg_done) begin
         cnt_q <= step;
         if (step == ALL_ONES)
            active_q <= 1'b0;
      end
   end

endmodule

// File: rtl/bcx_evt_flags.sv
module bcx_evt_flags
   import bcx_pkg::*;
#(
   parameter int MASK_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic                  stat_rd,
   input  logic [1:0]            mode,
   input  logic                  msg_done,
   input  logic [NUM_FAULTS-1:0] faults,
   input  logic                  run_done,
   input  logic [MASK_W-1:0]     mask,
   output logic [MASK_W-1:0]     flags_q,
   output logic                  irq
);

   logic [MASK_W-1:0] set_v;
   logic              irq_raw;

   always_comb begin
      set_v          = '0;
      set_v[EOM_BIT] = msg_done && !mode[1];
      set_v[FMT_BIT] = |faults;
      set_v[RUN_BIT] = run_done;
      irq_raw        = |(flags_q & mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags_q <= '0;
      else if (soft_rst)
         flags_q <= '0;
      else
         flags_q <= (stat_rd ? '0 : flags_q) | set_v;
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate

endmodule

// File: rtl/bcx_irq_seq.sv
module bcx_irq_seq
   import bcx_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 2,
   parameter int MASK_W   = 8,
   parameter int CNT_W    = 16,
   parameter int MAX_MSGS = 256,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [1:0]        mode,
   input  logic [CNT_W-1:0]  cnt_init,
   input  logic              ev_msg_done,
   input  logic              ev_loop_fail,
   input  logic              ev_msg_err,
   input  logic              ev_timeout,
   input  logic              ev_status_set,
   output logic              irq,
   output logic              ctrl_active,
   output logic              cfg_clear
);

   generate
      if (DATA_W < MASK_W) begin : g_chk_dw
         $error("DATA_W must cover MASK_W");
      end
      if (MASK_W <= RUN_BIT) begin : g_chk_mw
         $error("MASK_W too small for flag positions");
      end
      if (ADDR_W < 2) begin : g_chk_aw
         $error("ADDR_W must reach three registers");
      end
      if (MAX_MSGS < 1 || MAX_MSGS >= (2 ** CNT_W) - 1) begin : g_chk_max
         $error("MAX_MSGS out of range for CNT_W");
      end
   endgenerate

   logic                  soft_rst;
   logic                  start_cmd;
   logic                  stat_rd;
   logic [MASK_W-1:0]     mask_q;
   logic [MASK_W-1:0]     flag_q;
   logic                  run_done;
   logic [CNT_W-1:0]      cnt_q;
   logic [NUM_FAULTS-1:0] fault_v;

   assign fault_v = {ev_status_set, ev_timeout, ev_msg_err, ev_loop_fail};

   bcx_host_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .MASK_W (MASK_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .flags      (flag_q),
      .soft_rst   (soft_rst),
      .start_cmd  (start_cmd),
      .stat_rd    (stat_rd),
      .mask_q     (mask_q),
      .cfg_clear  (cfg_clear),
      .host_rdata (host_rdata)
   );

   bcx_msg_seq #(
      .CNT_W    (CNT_W),
      .MAX_MSGS (MAX_MSGS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .start_cmd (start_cmd),
      .mode      (mode),
      .cnt_init  (cnt_init),
      .msg_done  (ev_msg_done),
      .active_q  (ctrl_active),
      .run_done  (run_done),
      .cnt_q     (cnt_q)
   );

   bcx_evt_flags #(
      .MASK_W  (MASK_W),
      .IRQ_REG (IRQ_REG)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .stat_rd  (stat_rd),
      .mode     (mode),
      .msg_done (ev_msg_done),
      .faults   (fault_v),
      .run_done (run_done),
      .mask     (mask_q),
      .flags_q  (flag_q),
      .irq      (irq)
   );

endmodule

// File: rtl/bcx_irq_seq_chk.sv
module bcx_irq_seq_chk
   import bcx_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 2,
   parameter int MASK_W = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              host_rd,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_wdata,
   input logic [DATA_W-1:0] host_rdata,
   input logic [1:0]        mode,
   input logic              ev_msg_done,
   input logic              ev_loop_fail,
   input logic              ev_msg_err,
   input logic              ev_timeout,
   input logic              ev_status_set,
   input logic              ctrl_active,
   input logic              cfg_clear,
   input logic [MASK_W-1:0] flag_q,
   input logic [CNT_W-1:0]  cnt_q
);

   logic rst_wr;
   logic any_fault;
   assign rst_wr    = host_wr && (host_addr == ADDR_W'(ADDR_CMD)) && host_wdata[CMD_RST_BIT];
   assign any_fault = ev_loop_fail || ev_msg_err || ev_timeout || ev_status_set;

   // R4
   reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_wr |=> (!ctrl_active && cfg_clear && flag_q == '0));

   // R4
   cfg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_clear |=> !cfg_clear);

   // R3
   cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == ADDR_W'(ADDR_CMD)) |-> host_rdata == '0);

   // R5
   eom_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_msg_done && !mode[1] && !rst_wr) |=> flag_q[EOM_BIT]);

   // R6
   fmt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_fault && !rst_wr) |=> flag_q[FMT_BIT]);

   // R7
   run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_active && mode == MODE_BC && ev_msg_done && !host_wr &&
       cnt_q == {{(CNT_W-1){1'b1}}, 1'b0})
      |=> (!ctrl_active && flag_q[RUN_BIT]));

endmodule

bind bcx_irq_seq bcx_irq_seq_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .MASK_W (MASK_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_wr       (host_wr),
   .host_rd       (host_rd),
   .host_addr     (host_addr),
   .host_wdata    (host_wdata),
   .host_rdata    (host_rdata),
   .mode          (mode),
   .ev_msg_done   (ev_msg_done),
   .ev_loop_fail  (ev_loop_fail),
   .ev_msg_err    (ev_msg_err),
   .ev_timeout    (ev_timeout),
   .ev_status_set (ev_status_set),
   .ctrl_active   (ctrl_active),
   .cfg_clear     (cfg_clear),
   .flag_q        (flag_q),
   .cnt_q         (cnt_q)
);

// File: tb/bcx_irq_seq_tb.sv
module bcx_irq_seq_tb;

   localparam int DATA_W   = 16;
   localparam int ADDR_W   = 2;
   localparam int CNT_W    = 16;
   localparam int MAX_MSGS = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_wr = 1'b0;
   logic              host_rd = 1'b0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic [DATA_W-1:0] host_wdata = '0;
   logic [DATA_W-1:0] host_rdata;
   logic [1:0]        mode = 2'd0;
   logic [CNT_W-1:0]  cnt_init = '0;
   logic              ev_msg_done = 1'b0;
   logic              ev_loop_fail = 1'b0;
   logic              ev_msg_err = 1'b0;
   logic              ev_timeout = 1'b0;
   logic              ev_status_set = 1'b0;
   logic              irq;
   logic              ctrl_active;
   logic              cfg_clear;

   always #2 clk = ~clk;

   bcx_irq_seq #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .MASK_W   (8),
      .CNT_W    (CNT_W),
      .MAX_MSGS (MAX_MSGS),
      .IRQ_REG  (1'b0)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .host_wr       (host_wr),
      .host_rd       (host_rd),
      .host_addr     (host_addr),
      .host_wdata    (host_wdata),
      .host_rdata    (host_rdata),
      .mode          (mode),
      .cnt_init      (cnt_init),
      .ev_msg_done   (ev_msg_done),
      .ev_loop_fail  (ev_loop_fail),
      .ev_msg_err    (ev_msg_err),
      .ev_timeout    (ev_timeout),
      .ev_status_set (ev_status_set),
      .irq           (irq),
      .ctrl_active   (ctrl_active),
      .cfg_clear     (cfg_clear)
   );

   // behavioural reference state
   int    m_mask;
   int    m_flags;
   int    m_left;
   bit    m_active;
   bit    m_cfg;
   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   bit    finished = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mask = 0; m_flags = 0; m_left = 0; m_active = 0; m_cfg = 0;
      end else begin
         bit wr_cmd, srst, st;
         int nf;
         wr_cmd = host_wr && host_addr == 1;
         srst   = wr_cmd && host_wdata[0];
         st     = wr_cmd && host_wdata[1] && !srst;
         m_cfg  = srst;
         if (srst) begin
            m_mask = 0; m_flags = 0; m_left = 0; m_active = 0;
         end else begin
            nf = m_flags;
            if (host_rd && host_addr == 2) nf = 0;
            if (ev_msg_done && mode < 2) nf = nf | 1;
            if (ev_loop_fail || ev_msg_err || ev_timeout || ev_status_set) nf = nf | 2;
            if (st) begin
               if (mode == 0) begin
                  int n;
                  n = 65535 - int'(cnt_init);
                  if (n > MAX_MSGS) n = MAX_MSGS;
                  if (n == 0) begin
                     m_active = 0; nf = nf | 16;
                  end else begin
                     m_active = 1; m_left = n;
                  end
               end else if (mode >= 2) begin
                  m_active = 1;
               end
            end else if (m_active && mode == 0 && ev_msg_done) begin
               m_left = m_left - 1;
               if (m_left == 0) begin
                  m_active = 0; nf = nf | 16;
               end
            end
            if (host_wr && host_addr == 0) m_mask = int'(host_wdata) & 'h13;
            m_flags = nf;
         end
      end
   end

   task automatic check(string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: %s actual=%0h expected=%0h", cur_req, what, act, exp);
      end
   endtask

   // compare every cycle, after the negedge drive has settled
   always begin
      int exp_rd;
      @(negedge clk);
      #1;
      exp_rd = (host_addr == 0) ? m_mask : (host_addr == 2) ? m_flags : 0;
      check("irq", int'(irq), ((m_flags & m_mask) != 0) ? 1 : 0);
      check("ctrl_active", int'(ctrl_active), int'(m_active));
      check("cfg_clear", int'(cfg_clear), int'(m_cfg));
      check("host_rdata", int'(host_rdata), exp_rd);
   end

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         host_wr = 0; host_rd = 0;
         ev_msg_done = 0; ev_loop_fail = 0; ev_msg_err = 0;
         ev_timeout = 0; ev_status_set = 0;
      end
   endtask

   task automatic wr(int addr, int data);
      @(negedge clk);
      host_wr = 1; host_rd = 0;
      host_addr = ADDR_W'(addr); host_wdata = DATA_W'(data);
      idle(1);
   endtask

   task automatic rd(int addr);
      @(negedge clk);
      host_rd = 1; host_wr = 0; host_addr = ADDR_W'(addr);
      idle(1);
   endtask

   task automatic done_pulse();
      @(negedge clk);
      ev_msg_done = 1;
      idle(1);
   endtask

   task automatic fault_pulse(int which);
      @(negedge clk);
      ev_loop_fail  = (which == 0);
      ev_msg_err    = (which == 1);
      ev_timeout    = (which == 2);
      ev_status_set = (which == 3);
      idle(1);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      cur_req = "R1";
      idle(3);
      rst_n = 1;
      idle(3);
      host_addr = 0; idle(1);
      host_addr = 2; idle(1);

      cur_req = "R2";
      mode = 0;
      wr(0, 'hFFFF);
      host_addr = 0; idle(2);
      wr(0, 'h00EC);
      host_addr = 0; idle(1);
      wr(0, 'h0013);

      cur_req = "R3";
      rd(1);
      host_addr = 3; idle(1);

      cur_req = "R5";
      done_pulse();
      host_addr = 2; idle(1);
      rd(2);
      mode = 1; done_pulse(); rd(2);
      mode = 2; done_pulse(); host_addr = 2; idle(1);
      mode = 3; done_pulse(); idle(1);

      cur_req = "R6";
      for (int f = 0; f < 4; f++) begin
         fault_pulse(f);
         host_addr = 2; idle(1);
         rd(2);
      end

      cur_req = "R10";
      mode = 0;
      fault_pulse(0);
      @(negedge clk);
      host_rd = 1; host_addr = 2; ev_msg_done = 1;
      idle(1);
      host_addr = 2; idle(1);
      rd(2);

      cur_req = "R7";
      cnt_init = 16'hFFFC;
      wr(1, 2);
      idle(2);
      done_pulse(); idle(1);
      done_pulse(); idle(1);
      done_pulse();
      host_addr = 2; idle(2);
      rd(2);

      cur_req = "R8";
      cnt_init = 16'h0000;
      wr(1, 2);
      for (int k = 0; k < MAX_MSGS; k++) done_pulse();
      host_addr = 2; idle(1);
      rd(2);
      cnt_init = 16'hFFFF;
      wr(1, 2);
      host_addr = 2; idle(2);
      rd(2);

      cur_req = "R9";
      mode = 2;
      wr(1, 2);
      done_pulse(); done_pulse(); idle(2);
      wr(1, 1);
      mode = 1;
      wr(1, 2);
      idle(2);

      cur_req = "R11";
      mode = 0;
      wr(0, 'h10);
      done_pulse();
      host_addr = 2; idle(1);
      wr(0, 'h01);
      idle(1);
      rd(2);
      fault_pulse(2);
      idle(1);
      wr(0, 'h02);
      idle(1);

      cur_req = "R4";
      wr(0, 'h13);
      fault_pulse(1);
      cnt_init = 16'hFFFD;
      wr(1, 3);
      host_addr = 0; idle(3);
      cnt_init = 16'hFFFD;
      wr(1, 2);
      idle(1);
      fault_pulse(3);
      @(negedge clk);
      host_wr = 1; host_addr = 1; host_wdata = 1; ev_msg_done = 1;
      idle(1);
      host_addr = 2; idle(2);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule